// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block passes single-word messages between two processors, side A and side B, that share one clock. Each side has its own memory-mapped register port and its own interrupt line. Four one-word channels run in each direction. A word that one side writes to its transmit register for channel n shows up in the other side's receive register for channel n. A full/empty handshake flag goes with each slot.

The writer sees a per-channel transmit-empty flag, which means the last word has been taken and a new one may be sent. The reader sees a per-channel receive-full flag, which means a word is waiting. A control register on each side holds one enable per flag. The side's interrupt is the OR of every status flag ANDed with its enable, so software can wait for "space to send" or "data arrived" on any channel through one line.

Top module: `mbox_dual`

## Requirements
- R1: After reset, on both sides every transmit-empty flag reads 1, every receive-full flag reads 0, the control register reads 0 and the interrupt output is low.
- R2: Byte offsets on each side: the transmit register of channel n is at 0x00+4n, the receive register of channel n is at 0x10+4n, status is at 0x20 and control is at 0x24. Transmit registers and unmapped offsets read as 0.
- R3: One cycle after a side writes transmit register n, the writer's transmit-empty flag n is 0, the peer's receive-full flag n is 1, and the peer's receive register n holds the word.
- R4: A read of receive register n returns the pending word. One cycle later the reader's receive-full flag n is 0 and the peer's transmit-empty flag n is 1.
- R5: In the status word, transmit-empty of channel n is bit 20+(3-n) and receive-full of channel n is bit 24+(3-n). All other bits read 0.
- R6: The control register is read/write. The transmit-interrupt enable of channel n is bit 20+(3-n) and the receive-interrupt enable is bit 24+(3-n). Every other bit ignores writes and reads 0.
- R7: A side's interrupt is high exactly while some channel has transmit-empty set with its transmit enable set, or receive-full set with its receive enable set.
- R8: Writes to the status register have no effect on any flag.
- R9: A write to a transmit register whose peer slot is still full replaces the pending word and leaves both flags unchanged.
- R10: When a write to transmit register n and the peer's read of receive register n fall in the same cycle, the read returns the old word and the write wins: afterwards the peer's receive-full n is 1 and the writer's transmit-empty n is 0.
- R11: Each channel and each direction is independent. An access to one slot changes no other slot's flag or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_addr_i | input | 6 | Side A byte address |
| a_we_i | input | 1 | Side A write strobe |
| a_wdata_i | input | 32 | Side A write data |
| a_re_i | input | 1 | Side A read strobe |
| a_rdata_o | output | 32 | Side A read data, combinational while a_re_i is high |
| a_irq_o | output | 1 | Side A interrupt |
| b_addr_i | input | 6 | Side B byte address |
| b_we_i | input | 1 | Side B write strobe |
| b_wdata_i | input | 32 | Side B write data |
| b_re_i | input | 1 | Side B read strobe |
| b_rdata_o | output | 32 | Side B read data, combinational while b_re_i is high |
| b_irq_o | output | 1 | Side B interrupt |

## Verification
The assertions assume that each side issues at most one access per cycle, so a port never raises a write and a read on the same cycle. They also assume that a read strobe has a side effect only on the cycle it is sampled. The bench drives each side through tasks that assert one strobe for exactly one cycle. Only the simultaneous-access case drives both sides in the same cycle, and there it is one write on one side and one read on the other. A sweep over every control bit checks the interrupt against flag states the bench predicts.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned TX_BASE = 'h00;
  localparam int unsigned RX_BASE = 'h10;
  localparam int unsigned SR_OFF  = 'h20;
  localparam int unsigned CR_OFF  = 'h24;
  localparam int unsigned TE_LSB  = 20;
  localparam int unsigned RF_LSB  = 24;

  // channel order is reversed inside each nibble
  function automatic int unsigned te_pos(int unsigned n, int unsigned nch);
    return TE_LSB + nch - 1 - n;
  endfunction

  function automatic int unsigned rf_pos(int unsigned n, int unsigned nch);
    return RF_LSB + nch - 1 - n;
  endfunction
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      full_o <= 1'b1;        // write wins over a same-cycle read
      data_o <= wdata_i;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           re_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           irq_o,
  output logic [NUM_CH-1:0]              tx_wr_o,
  output logic [NUM_CH-1:0]              rx_rd_o,
  input  logic [NUM_CH-1:0]              tx_full_i,
  input  logic [NUM_CH-1:0]              rx_full_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  rx_data_i
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  function automatic logic [DATA_W-1:0] en_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned n = 0; n < NUM_CH; n++) begin
      m[te_pos(n, NUM_CH)] = 1'b1;
      m[rf_pos(n, NUM_CH)] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CR_MASK = en_mask();

  logic [ADDR_W-1:0] tx_off, rx_off;
  logic              tx_hit, rx_hit, sr_hit, cr_hit;
  logic [CH_W-1:0]   tx_idx, rx_idx;
  logic [DATA_W-1:0] ctrl_q, status;

  assign tx_off = addr_i - ADDR_W'(TX_BASE);
  assign rx_off = addr_i - ADDR_W'(RX_BASE);
  assign tx_hit = (tx_off < ADDR_W'(4 * NUM_CH)) && (tx_off[1:0] == 2'b00);
  assign rx_hit = (rx_off < ADDR_W'(4 * NUM_CH)) && (rx_off[1:0] == 2'b00);
  assign sr_hit = (addr_i == ADDR_W'(SR_OFF));
  assign cr_hit = (addr_i == ADDR_W'(CR_OFF));
  assign tx_idx = tx_off[CH_W+1:2];
  assign rx_idx = rx_off[CH_W+1:2];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_strb
    assign tx_wr_o[n] = we_i && tx_hit && (tx_idx == CH_W'(n));
    assign rx_rd_o[n] = re_i && rx_hit && (rx_idx == CH_W'(n));
  end

  always_comb begin
    status = '0;
    for (int unsigned n = 0; n < NUM_CH; n++) begin
      status[te_pos(n, NUM_CH)] = ~tx_full_i[n];
      status[rf_pos(n, NUM_CH)] = rx_full_i[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (we_i && cr_hit)    ctrl_q <= wdata_i & CR_MASK;
  end

  // enables share the status bit layout
  assign irq_o = |(status & ctrl_q);

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (rx_hit)      rdata_o = rx_data_i[rx_idx];
      else if (sr_hit) rdata_o = status;
      else if (cr_hit) rdata_o = ctrl_q;
    end
  end
endmodule

// File: rtl/mbox_dual.sv
module mbox_dual #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              a_re_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic              b_re_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_o
);
  logic [NUM_CH-1:0]             a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NUM_CH-1:0]             ab_full, ba_full;
  logic [NUM_CH-1:0][DATA_W-1:0] ab_data, ba_data;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    mbox_slot #(.DATA_W(DATA_W)) u_ab (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(a_tx_wr[n]), .wdata_i(a_wdata_i),
      .rd_i(b_rx_rd[n]), .full_o(ab_full[n]), .data_o(ab_data[n]));
    mbox_slot #(.DATA_W(DATA_W)) u_ba (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(b_tx_wr[n]), .wdata_i(b_wdata_i),
      .rd_i(a_rx_rd[n]), .full_o(ba_full[n]), .data_o(ba_data[n]));
  end

  mbox_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pa (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(a_addr_i), .we_i(a_we_i),
    .wdata_i(a_wdata_i), .re_i(a_re_i), .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .tx_wr_o(a_tx_wr), .rx_rd_o(a_rx_rd), .tx_full_i(ab_full),
    .rx_full_i(ba_full), .rx_data_i(ba_data));

  mbox_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pb (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(b_addr_i), .we_i(b_we_i),
    .wdata_i(b_wdata_i), .re_i(b_re_i), .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .tx_wr_o(b_tx_wr), .rx_rd_o(b_rx_rd), .tx_full_i(ba_full),
    .rx_full_i(ab_full), .rx_data_i(ab_data));
endmodule

// File: rtl/mbox_dual_chk.sv
module mbox_dual_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CH-1:0]             a_tx_wr,
  input logic [NUM_CH-1:0]             a_rx_rd,
  input logic [NUM_CH-1:0]             b_tx_wr,
  input logic [NUM_CH-1:0]             b_rx_rd,
  input logic [NUM_CH-1:0]             ab_full,
  input logic [NUM_CH-1:0]             ba_full,
  input logic [NUM_CH-1:0][DATA_W-1:0] ab_data,
  input logic [NUM_CH-1:0][DATA_W-1:0] ba_data,
  input logic [DATA_W-1:0]             a_wdata_i,
  input logic [DATA_W-1:0]             b_wdata_i,
  input logic                          a_irq_o,
  input logic                          b_irq_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    AST_AB_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_tx_wr[n] |=> ab_full[n]); // R3
    AST_BA_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_tx_wr[n] |=> ba_full[n]); // R3
    AST_AB_WR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_tx_wr[n] |=> ab_data[n] == $past(a_wdata_i)); // R3
    AST_BA_WR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_tx_wr[n] |=> ba_data[n] == $past(b_wdata_i)); // R3
    AST_AB_RD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_rx_rd[n] && !a_tx_wr[n] |=> !ab_full[n]); // R4
    AST_BA_RD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_rx_rd[n] && !b_tx_wr[n] |=> !ba_full[n]); // R4
    AST_AB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !a_tx_wr[n] && !b_rx_rd[n] |=> $stable(ab_full[n]) && $stable(ab_data[n])); // R11
    AST_BA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !b_tx_wr[n] && !a_rx_rd[n] |=> $stable(ba_full[n]) && $stable(ba_data[n])); // R11
  end

  AST_A_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_irq_o |-> (!(&ab_full) || (|ba_full))); // R7
  AST_B_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_irq_o |-> (!(&ba_full) || (|ab_full))); // R7
  AST_ONE_RX_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(a_rx_rd) && $onehot0(b_rx_rd)); // R2
  AST_ONE_TX_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(a_tx_wr) && $onehot0(b_tx_wr)); // R2
endmodule

bind mbox_dual mbox_dual_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_tx_wr(a_tx_wr), .a_rx_rd(a_rx_rd),
  .b_tx_wr(b_tx_wr), .b_rx_rd(b_rx_rd), .ab_full(ab_full), .ba_full(ba_full),
  .ab_data(ab_data), .ba_data(ba_data), .a_wdata_i(a_wdata_i),
  .b_wdata_i(b_wdata_i), .a_irq_o(a_irq_o), .b_irq_o(b_irq_o));

// File: tb/sim_mbox_dual.sv
`timescale 1ns/1ps
module sim_mbox_dual;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0]  a_addr_i = '0, b_addr_i = '0;
  logic        a_we_i = 1'b0, a_re_i = 1'b0, b_we_i = 1'b0, b_re_i = 1'b0;
  logic [31:0] a_wdata_i = '0, b_wdata_i = '0;
  logic [31:0] a_rdata_o, b_rdata_o;
  logic        a_irq_o, b_irq_o;

  int n_vec = 0, n_bad = 0;
  bit          ab_f[4], ba_f[4];
  logic [31:0] ab_d[4], ba_d[4];
  logic [31:0] cr_m[2];
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  mbox_dual u0 (.*);

  function automatic logic [31:0] exp_sr(int s);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[20 + 3 - n] = (s == 0) ? !ab_f[n] : !ba_f[n];
      v[24 + 3 - n] = (s == 0) ?  ba_f[n] :  ab_f[n];
    end
    return v;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(int s, logic [5:0] ad, logic [31:0] d);
    @(negedge clk_i);
    if (s == 0) begin a_addr_i = ad; a_wdata_i = d; a_we_i = 1'b1; end
    else        begin b_addr_i = ad; b_wdata_i = d; b_we_i = 1'b1; end
    @(posedge clk_i); #1;
    a_we_i = 1'b0; b_we_i = 1'b0;
  endtask

  task automatic rdx(int s, logic [5:0] ad, output logic [31:0] d);
    @(negedge clk_i);
    if (s == 0) begin a_addr_i = ad; a_re_i = 1'b1; end
    else        begin b_addr_i = ad; b_re_i = 1'b1; end
    #1 d = (s == 0) ? a_rdata_o : b_rdata_o;
    @(posedge clk_i); #1;
    a_re_i = 1'b0; b_re_i = 1'b0;
  endtask

  task automatic chk_sr(string r);
    logic [31:0] v;
    rdx(0, 6'h20, v); chk({r, " status A"}, v, exp_sr(0));
    rdx(1, 6'h20, v); chk({r, " status B"}, v, exp_sr(1));
  endtask

  task automatic chk_irq(string r);
    chk({r, " irq A"}, {31'd0, a_irq_o}, {31'd0, |(exp_sr(0) & cr_m[0])});
    chk({r, " irq B"}, {31'd0, b_irq_o}, {31'd0, |(exp_sr(1) & cr_m[1])});
  endtask

  task automatic send(int s, int n, logic [31:0] d);
    wr(s, 6'(4 * n), d);
    if (s == 0) begin ab_f[n] = 1; ab_d[n] = d; end
    else        begin ba_f[n] = 1; ba_d[n] = d; end
  endtask

  task automatic recv(int s, int n, string r);
    logic [31:0] v;
    rdx(s, 6'(16 + 4 * n), v);
    chk(r, v, (s == 0) ? ba_d[n] : ab_d[n]);
    if (s == 0) ba_f[n] = 0; else ab_f[n] = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 4; n++) begin ab_f[n] = 0; ba_f[n] = 0; ab_d[n] = 0; ba_d[n] = 0; end
    cr_m[0] = 0; cr_m[1] = 0;
    #9 rst_ni = 1'b1;

    // R1 reset state
    chk_sr("R1");
    rdx(0, 6'h24, rd); chk("R1 ctrl A", rd, 32'h0);
    rdx(1, 6'h24, rd); chk("R1 ctrl B", rd, 32'h0);
    chk_irq("R1");

    // R3 R4 R5 sweep of every side and channel
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 4; n++) begin
        send(s, n, 32'hC0DE0000 ^ (s << 12) ^ (n * 32'h01010101));
        chk_sr("R3 R5 after send");
        recv(1 - s, n, "R4 rx data");
        chk_sr("R4 R5 after recv");
      end

    // R11 fill all, drain in reverse, checking others untouched
    for (int n = 0; n < 4; n++) begin send(0, n, 32'h1000 + n); send(1, n, 32'h2000 + n); end
    chk_sr("R11 all full");
    for (int n = 3; n >= 0; n--) begin
      recv(1, n, "R11 rx B"); chk_sr("R11 drain");
      recv(0, n, "R11 rx A"); chk_sr("R11 drain");
    end

    // R2 transmit registers and holes read zero
    send(0, 2, 32'hFEEDBEEF);
    rdx(0, 6'h08, rd); chk("R2 tx reads zero", rd, 32'h0);
    rdx(1, 6'h28, rd); chk("R2 hole reads zero", rd, 32'h0);
    rdx(1, 6'h3C, rd); chk("R2 hole reads zero", rd, 32'h0);
    rdx(1, 6'h18, rd); chk("R2 rx ch2 offset", rd, 32'hFEEDBEEF); ab_f[2] = 0;

    // R8 status writes ignored
    send(1, 0, 32'h55);
    wr(0, 6'h20, 32'hFFFFFFFF); wr(1, 6'h20, 32'h0);
    chk_sr("R8");
    recv(0, 0, "R8 rx A");

    // R6 R7 sweep every control bit under a mixed flag state
    send(0, 1, 32'hAAAA0001);
    send(1, 2, 32'hBBBB0002);
    for (int k = 0; k < 32; k++)
      for (int s = 0; s < 2; s++) begin
        wr(s, 6'h24, 32'h1 << k);
        cr_m[s] = (32'h1 << k) & 32'h0FF00000;
        rdx(s, 6'h24, rd); chk("R6 ctrl readback", rd, cr_m[s]);
        chk_irq("R7 single enable");
      end
    wr(0, 6'h24, 32'hFFFFFFFF); cr_m[0] = 32'h0FF00000;
    wr(1, 6'h24, 32'h0F000000); cr_m[1] = 32'h0F000000;
    chk_irq("R7 all enables");
    recv(0, 2, "R7 rx A"); recv(1, 1, "R7 rx B");
    chk_irq("R7 after drain");
    wr(0, 6'h24, 32'h0); cr_m[0] = 0;
    wr(1, 6'h24, 32'h0); cr_m[1] = 0;
    chk_irq("R7 disabled");

    // R9 overwrite while full
    send(0, 3, 32'h11111111);
    send(0, 3, 32'h22222222);
    chk_sr("R9 flags unchanged");
    recv(1, 3, "R9 newest word");

    // R10 write and peer read together
    send(1, 0, 32'h0000AAAA);
    @(negedge clk_i);
    b_addr_i = 6'h00; b_wdata_i = 32'h0000BBBB; b_we_i = 1'b1;
    a_addr_i = 6'h10; a_re_i = 1'b1;
    #1 rd = a_rdata_o;
    @(posedge clk_i); #1;
    b_we_i = 1'b0; a_re_i = 1'b0;
    chk("R10 old word read", rd, 32'h0000AAAA);
    ba_d[0] = 32'h0000BBBB;
    chk_sr("R10 write wins");
    recv(0, 0, "R10 new word");
    chk_sr("R10 final");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule